// File: doc/BRIEF.md
# Raster Display Timing Generator

This block drives the synchronisation and colour pins of a raster monitor from a single pixel clock. It keeps a pixel counter and a line counter and decodes the visible window, the front porch, the sync pulse and the back porch on each axis. The bounds of each axis come from a configuration record. The record holds the visible count, the front porch, the sync width, the back porch, the total count and the sync polarity. The default record describes a 640 by 480 mode. The default colour width is 4 bits per channel, and a 1-bit-per-channel build is also supported.

While the beam is inside the visible window, the block places a column and row address on its pixel-fetch port. An external source registers the matching colour and returns it one clock later. The block delays its visible flag and both sync levels by one register stage so that they line up with the returned colour. Outside the window it forces the colour pins to zero. A clock enable advances the raster one pixel per enabled clock. An asynchronous active-low reset returns the raster to pixel 0 of line 0.

Top module: `vtc_raster_top`

## Requirements
- R1: While reset is asserted and after its release, until the first enabled clock, the column and row addresses are 0, the colour outputs are 0, and both sync outputs sit at their inactive level.
- R2: The column address equals the pixel count and the row address equals the line count when the pixel count is below the horizontal visible count and the line count is below the vertical visible count. Otherwise both addresses are 0.
- R3: The pixel count rises by one on each enabled clock. After total-1 it returns to 0, and on that same clock the line count advances. The line count changes on no other clock.
- R4: After the enabled clock that ends line total-1 of the vertical record, the line count returns to 0.
- R5: The horizontal sync output is at its active level exactly when the pixel count presented one enabled clock earlier lay in [visible+front porch, visible+front porch+sync width).
- R6: The vertical sync output follows the rule of R5 using the line count, and it is delayed by the same stage as the horizontal sync.
- R7: One clock after an address is presented, the colour outputs equal the colour the source returned for that address if the address lay in the visible window. Otherwise they are 0.
- R8: While the enable input is low, the counters, the addresses, both syncs and the colours keep their values.
- R9: Each axis record carries a polarity bit, where 1 means active-low sync and 0 means active-high. The default is active-low on both axes.
- R10: The colour width per channel is a parameter, and a width of 1 behaves as in R7 using only that single bit per channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock enable; advances the raster by one pixel |
| addr_col | output | clog2(H visible) | Column address to the pixel source |
| addr_row | output | clog2(V visible) | Row address to the pixel source |
| src_red | input | COLOR_W | Red value returned by the source, one clock after the address |
| src_grn | input | COLOR_W | Green value returned by the source |
| src_blu | input | COLOR_W | Blue value returned by the source |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| red | output | COLOR_W | Red pin, zero while blanked |
| grn | output | COLOR_W | Green pin, zero while blanked |
| blu | output | COLOR_W | Blue pin, zero while blanked |

## Verification
The bench builds the block with a reduced record: 8 visible, 2 front porch, 3 sync, 2 back porch and 15 total pixels, over 4 visible, 1 front porch, 2 sync, 1 back porch and 8 total lines. One frame therefore takes 120 enabled clocks, so both wraps, every porch edge and several whole frames fall within a short run. A first copy uses 4-bit colour with active-low sync. A second copy, driven by the same stimulus, uses 1-bit colour with active-high sync, which covers the polarity bit and the narrow colour build against the same expected raster.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

  // One axis of raster timing; all counts in pixels (horizontal) or lines (vertical).
  typedef struct packed {
    logic [15:0] visible;
    logic [15:0] front;
    logic [15:0] sync;
    logic [15:0] back;
    logic [15:0] total;
    logic        active_low;
  } axis_t;

  localparam axis_t H_640 = '{16'd640, 16'd16, 16'd96, 16'd48, 16'd800, 1'b1};
  localparam axis_t V_480 = '{16'd480, 16'd10, 16'd2, 16'd33, 16'd525, 1'b1};

  function automatic int cnt_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/vtc_axis_ctr.sv
module vtc_axis_ctr
  import vtc_pkg::*;
#(
  parameter axis_t CFG = H_640,
  parameter int    CW  = cnt_bits(int'(CFG.total)),
  parameter int    AW  = cnt_bits(int'(CFG.visible))
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic [AW-1:0] addr,
  output logic          last,
  output logic          vis,
  output logic          sync_on
);

  localparam logic [CW-1:0] ONE        = CW'(1);
  localparam logic [15:0]   SYNC_BEGIN = CFG.visible + CFG.front;
  localparam logic [15:0]   SYNC_END   = CFG.visible + CFG.front + CFG.sync;
  localparam logic [15:0]   LAST_CNT   = CFG.total - 16'd1;

  logic [15:0] cnt_x;

  assign cnt_x   = 16'(cnt);
  assign last    = (cnt_x == LAST_CNT);
  assign vis     = (cnt_x < CFG.visible);
  assign sync_on = (cnt_x >= SYNC_BEGIN) && (cnt_x < SYNC_END);
  assign addr    = cnt[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= last ? '0 : cnt + ONE;
    end
  end

endmodule

// File: rtl/vtc_align.sv
module vtc_align #(
  parameter int   COLOR_W = 4,
  parameter logic H_LOW   = 1'b1,
  parameter logic V_LOW   = 1'b1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               vis_in,
  input  logic               hs_on,
  input  logic               vs_on,
  input  logic [COLOR_W-1:0] src_red,
  input  logic [COLOR_W-1:0] src_grn,
  input  logic [COLOR_W-1:0] src_blu,
  output logic               hsync,
  output logic               vsync,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] grn,
  output logic [COLOR_W-1:0] blu
);

  // Inactive sync level follows the polarity bit of each axis.
  localparam logic H_IDLE = H_LOW;
  localparam logic V_IDLE = V_LOW;

  logic vis_q;
  logic hs_q;
  logic vs_q;

  // One stage, matching the single register inside the pixel source.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q <= 1'b0;
      hs_q  <= H_IDLE;
      vs_q  <= V_IDLE;
    end else if (en) begin
      vis_q <= vis_in;
      hs_q  <= hs_on ? ~H_IDLE : H_IDLE;
      vs_q  <= vs_on ? ~V_IDLE : V_IDLE;
    end
  end

  assign hsync = hs_q;
  assign vsync = vs_q;
  assign red   = vis_q ? src_red : '0;
  assign grn   = vis_q ? src_grn : '0;
  assign blu   = vis_q ? src_blu : '0;

endmodule

// File: rtl/vtc_raster_top.sv
module vtc_raster_top
  import vtc_pkg::*;
#(
  parameter axis_t H_CFG   = H_640,
  parameter axis_t V_CFG   = V_480,
  parameter int    COLOR_W = 4
)(
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      en,
  output logic [cnt_bits(int'(H_CFG.visible))-1:0]  addr_col,
  output logic [cnt_bits(int'(V_CFG.visible))-1:0]  addr_row,
  input  logic [COLOR_W-1:0]                        src_red,
  input  logic [COLOR_W-1:0]                        src_grn,
  input  logic [COLOR_W-1:0]                        src_blu,
  output logic                                      hsync,
  output logic                                      vsync,
  output logic [COLOR_W-1:0]                        red,
  output logic [COLOR_W-1:0]                        grn,
  output logic [COLOR_W-1:0]                        blu
);

  localparam int HW = cnt_bits(int'(H_CFG.total));
  localparam int VW = cnt_bits(int'(V_CFG.total));
  localparam int CA = cnt_bits(int'(H_CFG.visible));
  localparam int RA = cnt_bits(int'(V_CFG.visible));

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic [CA-1:0] h_addr;
  logic [RA-1:0] v_addr;
  logic          h_last, h_vis, h_sync_on;
  logic          v_last, v_vis, v_sync_on;
  logic          in_window;

  vtc_axis_ctr #(.CFG(H_CFG), .CW(HW), .AW(CA)) u_hctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (en),
    .cnt     (h_cnt),
    .addr    (h_addr),
    .last    (h_last),
    .vis     (h_vis),
    .sync_on (h_sync_on)
  );

  vtc_axis_ctr #(.CFG(V_CFG), .CW(VW), .AW(RA)) u_vctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (en & h_last),
    .cnt     (v_cnt),
    .addr    (v_addr),
    .last    (v_last),
    .vis     (v_vis),
    .sync_on (v_sync_on)
  );

  assign in_window = h_vis & v_vis;
  assign addr_col  = in_window ? h_addr : '0;
  assign addr_row  = in_window ? v_addr : '0;

  vtc_align #(
    .COLOR_W (COLOR_W),
    .H_LOW   (H_CFG.active_low),
    .V_LOW   (V_CFG.active_low)
  ) u_align (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .vis_in  (in_window),
    .hs_on   (h_sync_on),
    .vs_on   (v_sync_on),
    .src_red (src_red),
    .src_grn (src_grn),
    .src_blu (src_blu),
    .hsync   (hsync),
    .vsync   (vsync),
    .red     (red),
    .grn     (grn),
    .blu     (blu)
  );

  // The line counter only consumes the last-pixel strobe of the other axis.
  logic unused_ok;
  assign unused_ok = v_last;

endmodule

// File: rtl/vtc_raster_chk.sv
module vtc_raster_chk
  import vtc_pkg::*;
#(
  parameter axis_t H_CFG   = H_640,
  parameter axis_t V_CFG   = V_480,
  parameter int    COLOR_W = 4,
  parameter int    HW      = cnt_bits(int'(H_CFG.total)),
  parameter int    VW      = cnt_bits(int'(V_CFG.total)),
  parameter int    CA      = cnt_bits(int'(H_CFG.visible))
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic [HW-1:0]        h_cnt,
  input logic [VW-1:0]        v_cnt,
  input logic [CA-1:0]        addr_col,
  input logic                 hsync,
  input logic                 vsync,
  input logic [3*COLOR_W-1:0] rgb
);

  localparam logic [HW-1:0] H_LAST  = HW'(H_CFG.total - 16'd1);
  localparam logic [VW-1:0] V_LAST  = VW'(V_CFG.total - 16'd1);
  localparam logic [HW-1:0] H_VIS_C = HW'(H_CFG.visible);
  localparam logic [HW-1:0] H_SYNC0 = HW'(H_CFG.visible + H_CFG.front);
  localparam logic          H_ON    = ~H_CFG.active_low;

  assert_hwrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && h_cnt == H_LAST) |=> (h_cnt == '0));

  assert_vsteady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en && h_cnt == H_LAST)) |=> $stable(v_cnt));

  assert_vwrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && h_cnt == H_LAST && v_cnt == V_LAST) |=> (v_cnt == '0));

  assert_addr_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt >= H_VIS_C) |-> (addr_col == '0));

  assert_hsync_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && h_cnt == H_SYNC0) |=> (hsync == H_ON));

  assert_rgb_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && h_cnt >= H_VIS_C) |=> (rgb == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> ($stable(h_cnt) && $stable(v_cnt) && $stable(hsync)
               && $stable(vsync) && $stable(rgb)));

endmodule

bind vtc_raster_top vtc_raster_chk #(
  .H_CFG   (H_CFG),
  .V_CFG   (V_CFG),
  .COLOR_W (COLOR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .h_cnt    (h_cnt),
  .v_cnt    (v_cnt),
  .addr_col (addr_col),
  .hsync    (hsync),
  .vsync    (vsync),
  .rgb      ({red, grn, blu})
);

// File: tb/tb_vtc_raster_top.sv
`timescale 1ns/1ps
module tb_vtc_raster_top;
  import vtc_pkg::*;

  localparam axis_t HC  = '{16'd8, 16'd2, 16'd3, 16'd2, 16'd15, 1'b1};
  localparam axis_t VC  = '{16'd4, 16'd1, 16'd2, 16'd1, 16'd8,  1'b1};
  localparam axis_t HCP = '{16'd8, 16'd2, 16'd3, 16'd2, 16'd15, 1'b0};
  localparam axis_t VCP = '{16'd4, 16'd1, 16'd2, 16'd1, 16'd8,  1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0] col_a, col_b;
  logic [1:0] row_a, row_b;
  logic [3:0] sr, sg, sb;
  logic       sr1, sg1, sb1;
  logic       hs_a, vs_a, hs_b, vs_b;
  logic [3:0] r_a, g_a, b_a;
  logic       r_b, g_b, b_b;

  vtc_raster_top #(.H_CFG(HC), .V_CFG(VC), .COLOR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .addr_col(col_a), .addr_row(row_a),
    .src_red(sr), .src_grn(sg), .src_blu(sb),
    .hsync(hs_a), .vsync(vs_a), .red(r_a), .grn(g_a), .blu(b_a));

  vtc_raster_top #(.H_CFG(HCP), .V_CFG(VCP), .COLOR_W(1)) dut_b (
    .clk(clk), .rst_n(rst_n), .en(en), .addr_col(col_b), .addr_row(row_b),
    .src_red(sr1), .src_grn(sg1), .src_blu(sb1),
    .hsync(hs_b), .vsync(vs_b), .red(r_b), .grn(g_b), .blu(b_b));

  function automatic logic [11:0] pix(input int c, input int r);
    return {4'(c + 1), 4'(r + 5), 4'(c * 3 + r)};
  endfunction

  // Pixel source models: one register, as the fetch port expects.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sr, sg, sb} <= '0;
      {sr1, sg1, sb1} <= '0;
    end else if (en) begin
      {sr, sg, sb} <= pix(int'(col_a), int'(row_a));
      sr1 <= pix(int'(col_b), int'(row_b))[8];
      sg1 <= pix(int'(col_b), int'(row_b))[4];
      sb1 <= pix(int'(col_b), int'(row_b))[0];
    end
  end

  int n_cmp = 0;
  int n_bad = 0;
  int rh = 0, rv = 0, ph = 0, pv = 0;
  bit pvalid = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_now();
    bit win, pwin, ehs, evs;
    logic [11:0] p;
    win = (rh < 8) && (rv < 4);
    chk("R2 addr_col", int'(col_a), win ? rh : 0);
    chk("R2 addr_row", int'(row_a), win ? rv : 0);
    if (pvalid) begin
      pwin = (ph < 8) && (pv < 4);
      ehs  = (ph >= 10) && (ph < 13);
      evs  = (pv >= 5) && (pv < 7);
      p    = pwin ? pix(ph, pv) : 12'h000;
      chk("R5 hsync", int'(hs_a), int'(!ehs));
      chk("R6 vsync", int'(vs_a), int'(!evs));
      chk("R7 rgb", int'({r_a, g_a, b_a}), int'(p));
      chk("R9 hsync active-high copy", int'(hs_b), int'(ehs));
      chk("R9 vsync active-high copy", int'(vs_b), int'(evs));
      chk("R10 one-bit rgb", int'({r_b, g_b, b_b}), int'({p[8], p[4], p[0]}));
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic tick(input bit e);
    en = e;
    @(posedge clk);
    if (e) begin
      ph = rh; pv = rv; pvalid = 1;
      if (rh == 14) begin
        rh = 0;
        rv = (rv == 7) ? 0 : rv + 1;
      end else begin
        rh = rh + 1;
      end
    end
    @(negedge clk);
    check_now();
    if (e && ph == 14) begin
      chk("R3 pixel wrap", int'(col_a), 0);
      chk("R3 line step", rv, (pv + 1) % 8);
      if (pv == 7) chk("R4 line wrap", int'(row_a), 0);
    end
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " R1 addr_col"}, int'(col_a), 0);
    chk({tag, " R1 addr_row"}, int'(row_a), 0);
    chk({tag, " R1 hsync"}, int'(hs_a), 1);
    chk({tag, " R1 vsync"}, int'(vs_a), 1);
    chk({tag, " R1 rgb"}, int'({r_a, g_a, b_a}), 0);
    chk({tag, " R1 hsync copy"}, int'(hs_b), 0);
    chk({tag, " R1 vsync copy"}, int'(vs_b), 0);
    chk({tag, " R1 rgb copy"}, int'({r_b, g_b, b_b}), 0);
  endtask

  task automatic test_reset();
    en = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check_reset_state("in reset");
    rst_n = 1;
    rh = 0; rv = 0; pvalid = 0;
    @(negedge clk);
    check_reset_state("after release");
  endtask

  task automatic test_frames();
    for (int i = 0; i < 250; i++) tick(1'b1);
  endtask

  task automatic test_enable_gaps();
    logic [11:0] rgb_s;
    logic [2:0]  col_s;
    logic        hs_s, vs_s;
    for (int i = 0; i < 200; i++) begin
      if (i % 3 == 1) begin
        rgb_s = {r_a, g_a, b_a}; col_s = col_a; hs_s = hs_a; vs_s = vs_a;
        tick(1'b0);
        chk("R8 rgb held", int'({r_a, g_a, b_a}), int'(rgb_s));
        chk("R8 addr held", int'(col_a), int'(col_s));
        chk("R8 hsync held", int'(hs_a), int'(hs_s));
        chk("R8 vsync held", int'(vs_a), int'(vs_s));
      end else begin
        tick(1'b1);
      end
    end
  endtask

  task automatic test_midframe_reset();
    for (int i = 0; i < 37; i++) tick(1'b1);
    en = 1;
    rst_n = 0;
    @(negedge clk);
    check_reset_state("mid-frame");
    rst_n = 1;
    rh = 0; rv = 0; pvalid = 0;
    en = 0;
    @(negedge clk);
    check_reset_state("restart");
    for (int i = 0; i < 130; i++) tick(1'b1);
  endtask

  initial begin
    #(20000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_frames();
    test_enable_gaps();
    test_midframe_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule